// File: doc/BRIEF.md
# Priority Hardware Thread Scheduler

This block decides which hardware thread the pipeline runs next. It serves three classes of thread. A parameterised set of hardware interrupt threads forms the top class. A single microkernel thread sits in the middle class, and a single emulated-code thread sits in the lowest class. Each thread has one runnable flag in a semaphore register. Other agents raise a flag through a set vector. Software lowers flags through an atomic bit-clear operation, which also returns the masked value. When the interrupt-enable level rises from 0 to 1, the microkernel's flag is raised, so that thread wakes up.

Every cycle a selector registers the best runnable thread. Hardware threads outrank the microkernel, and the microkernel outranks emulated code. Among hardware threads a round-robin pointer decides. A three-state controller offers the chosen thread to the decoder as a schedule request and holds it until the decoder acknowledges. The acknowledged thread then becomes the running thread. In preemptive mode a running thread of a lower class is displaced when a thread of a higher class becomes runnable. In cooperative mode only a yield ends the running thread.

The controller has three states. IDLE means no thread is running and none is offered. REQ means a request is presented and the controller is waiting for the acknowledge. RUN means a thread is executing. It has five transitions:
- IDLE to REQ (launch): a registered candidate exists and its flag is still set.
- REQ to RUN (accept): the acknowledge arrives.
- RUN to IDLE (yield): the running thread yields or blocks.
- RUN to REQ (preempt): preemptive mode is on and the candidate's class outranks the running class.
- REQ to REQ (hold): no acknowledge yet.

Top module: `thread_scheduler`

## Requirements
- R1: After reset there is no request (`sched_req_o`=0), no running thread (`cur_valid_o`=0) and all semaphore flags are 0. With no flag set, no request is ever raised.
- R2: Thread ids are fixed: hardware threads are 0..NUM_HW-1, the microkernel is NUM_HW and the emulated-code thread is NUM_HW+1. When any hardware flag is set, the thread offered is a hardware thread.
- R3: With no hardware flag set, the microkernel (id NUM_HW) is offered before the emulated-code thread (id NUM_HW+1).
- R4: Hardware threads are picked round-robin. The search starts at RR_INIT after reset. After hardware thread t is accepted, the search starts at t+1, wrapping from NUM_HW-1 to 0.
- R5: A request keeps `sched_req_o` high and `sched_thread_o` unchanged until `sched_ack_i` is seen, even if a higher-class flag is raised meanwhile. In the cycle after the acknowledge, `cur_valid_o`=1 and `cur_thread_o` equals the offered id. A request and a running thread never coexist.
- R6: With `preempt_i`=1, a running microkernel is displaced when a hardware flag is set, and a running emulated-code thread is displaced when a hardware or microkernel flag is set. A running hardware thread is never displaced.
- R7: With `preempt_i`=0, a running thread keeps running until it yields, whatever flags are raised.
- R8: `clr_result_o` equals the current flags with the bits of `clr_mask_i` cleared. When `clr_valid_i`=1, the flags take that value at the next edge, apart from bits being set in that same cycle.
- R9: A set (from `sem_set_i` or the interrupt-enable rise) arriving in the same cycle as a clear of the same bit wins: the bit ends up set. Clearing one bit never disturbs another.
- R10: A 0-to-1 change of `int_en_i` sets the microkernel flag (bit NUM_HW) at the next edge. Holding `int_en_i` high or lowering it sets nothing.
- R11: A `yield_i` pulse while a thread runs returns the controller to IDLE: `cur_valid_o` is 0 in the next cycle. The flags are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| preempt_i | input | 1 | 1 = preemptive, 0 = cooperative |
| yield_i | input | 1 | Running thread yields or blocks |
| int_en_i | input | 1 | Interrupt-enable level; its rising edge wakes the microkernel |
| sem_set_i | input | NUM_HW+2 | Flags to raise this cycle |
| clr_valid_i | input | 1 | Perform the bit-clear operation |
| clr_mask_i | input | NUM_HW+2 | Bits to clear |
| clr_result_o | output | NUM_HW+2 | Flags with the mask bits cleared |
| sem_flags_o | output | NUM_HW+2 | Current semaphore flags |
| sched_req_o | output | 1 | Schedule request to the decoder |
| sched_thread_o | output | TID_W | Thread id offered |
| sched_ack_i | input | 1 | Decoder accepts the request |
| cur_valid_o | output | 1 | A thread is running |
| cur_thread_o | output | TID_W | Id of the running (or last) thread |

## Verification
The hardest situations to reach are races. One is a set and a clear of the same flag in a single cycle. Another is a higher-class flag raised while a request is still waiting for its acknowledge. The bench creates both by holding back `sched_ack_i` and by driving `sem_set_i` and `clr_valid_i` together on the same falling edge. It also walks the round-robin pointer through a full wrap with every flag set. It does this by yielding each granted thread in turn, and it then switches between preemptive and cooperative mode with threads of each class running.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RUN  = 2'd2
    } sched_state_e;

    // Larger value means higher priority.
    typedef enum logic [1:0] {
        CL_EMU = 2'd0,
        CL_MK  = 2'd1,
        CL_HW  = 2'd2
    } thread_class_e;

    function automatic thread_class_e class_of(input int unsigned tid,
                                               input int unsigned num_hw);
        if (tid < num_hw)
            return CL_HW;
        else if (tid == num_hw)
            return CL_MK;
        else
            return CL_EMU;
    endfunction

    // True when a thread of class cand may displace a running thread of class run.
    function automatic logic outranks(input thread_class_e cand,
                                      input thread_class_e run);
        return cand > run;
    endfunction

endpackage

// File: rtl/sched_semaphores.sv
module sched_semaphores #(
    parameter int NT     = 6,
    parameter int MK_IDX = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NT-1:0] set_i,
    input  logic          clr_valid_i,
    input  logic [NT-1:0] clr_mask_i,
    input  logic          int_en_i,
    output logic [NT-1:0] flags_o,
    output logic [NT-1:0] clr_result_o
);

    logic [NT-1:0] flags_q, flags_d;
    logic [NT-1:0] wake_vec;
    logic [NT-1:0] kill_vec;
    logic          int_en_q;
    logic          int_rise;

    assign int_rise = int_en_i & ~int_en_q;

    // Per-bit wake sources: external set, plus the enable edge on the microkernel bit.
    for (genvar b = 0; b < NT; b++) begin : g_wake
        if (b == MK_IDX) begin : g_mk
            assign wake_vec[b] = set_i[b] | int_rise;
        end else begin : g_other
            assign wake_vec[b] = set_i[b];
        end
    end

    always_comb begin
        kill_vec     = clr_valid_i ? clr_mask_i : '0;
        clr_result_o = flags_q & ~clr_mask_i;
        // Set wins over clear: the read-modify-write never drops a concurrent set.
        flags_d      = (flags_q & ~kill_vec) | wake_vec;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flags_q  <= '0;
            int_en_q <= 1'b0;
        end else begin
            flags_q  <= flags_d;
            int_en_q <= int_en_i;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/sched_select.sv
module sched_select #(
    parameter int NUM_HW  = 4,
    parameter int RR_INIT = 0,
    parameter int TID_W   = 3,
    parameter int HW_W    = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_HW+1:0]   flags_i,
    input  logic                grant_hw_i,
    input  logic [HW_W-1:0]     grant_idx_i,
    output logic                next_valid_o,
    output logic [TID_W-1:0]    next_tid_o
);

    localparam int MK_ID  = NUM_HW;
    localparam int EMU_ID = NUM_HW + 1;

    logic [HW_W-1:0]  rr_q;
    logic             hw_hit;
    logic [HW_W-1:0]  hw_pick;
    logic             cand_valid;
    logic [TID_W-1:0] cand_tid;
    logic             next_valid_q;
    logic [TID_W-1:0] next_tid_q;

    // Rotating search over the hardware flags, starting at the pointer.
    always_comb begin
        hw_hit  = 1'b0;
        hw_pick = '0;
        for (int off = 0; off < NUM_HW; off++) begin
            int idx;
            idx = int'(rr_q) + off;
            if (idx >= NUM_HW)
                idx = idx - NUM_HW;
            if (!hw_hit && flags_i[idx]) begin
                hw_hit  = 1'b1;
                hw_pick = HW_W'(idx);
            end
        end
    end

    // Class priority: hardware, then microkernel, then emulated code.
    always_comb begin
        cand_valid = 1'b1;
        if (hw_hit)
            cand_tid = TID_W'(hw_pick);
        else if (flags_i[MK_ID])
            cand_tid = TID_W'(MK_ID);
        else if (flags_i[EMU_ID])
            cand_tid = TID_W'(EMU_ID);
        else begin
            cand_tid   = '0;
            cand_valid = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rr_q         <= HW_W'(RR_INIT);
            next_valid_q <= 1'b0;
            next_tid_q   <= '0;
        end else begin
            next_valid_q <= cand_valid;
            next_tid_q   <= cand_tid;
            if (grant_hw_i) begin
                if (int'(grant_idx_i) == NUM_HW - 1)
                    rr_q <= '0;
                else
                    rr_q <= grant_idx_i + HW_W'(1);
            end
        end
    end

    assign next_valid_o = next_valid_q;
    assign next_tid_o   = next_tid_q;

endmodule

// File: rtl/thread_scheduler.sv
module thread_scheduler #(
    parameter int NUM_HW  = 4,
    parameter int RR_INIT = 0,
    localparam int NT     = NUM_HW + 2,
    localparam int TID_W  = $clog2(NUM_HW + 2),
    localparam int HW_W   = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              preempt_i,
    input  logic              yield_i,
    input  logic              int_en_i,
    input  logic [NT-1:0]     sem_set_i,
    input  logic              clr_valid_i,
    input  logic [NT-1:0]     clr_mask_i,
    output logic [NT-1:0]     clr_result_o,
    output logic [NT-1:0]     sem_flags_o,
    output logic              sched_req_o,
    output logic [TID_W-1:0]  sched_thread_o,
    input  logic              sched_ack_i,
    output logic              cur_valid_o,
    output logic [TID_W-1:0]  cur_thread_o
);
    import sched_pkg::*;

    sched_state_e     state_q, state_d;
    logic [TID_W-1:0] req_tid_q;
    logic [TID_W-1:0] cur_tid_q;
    logic [NT-1:0]    flags;
    logic             nxt_valid;
    logic [TID_W-1:0] nxt_tid;
    logic             nxt_live;
    logic             nxt_wins;
    logic             grant_hw;
    logic             load_req;

    sched_semaphores #(
        .NT     (NT),
        .MK_IDX (NUM_HW)
    ) u_sem (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .set_i        (sem_set_i),
        .clr_valid_i  (clr_valid_i),
        .clr_mask_i   (clr_mask_i),
        .int_en_i     (int_en_i),
        .flags_o      (flags),
        .clr_result_o (clr_result_o)
    );

    sched_select #(
        .NUM_HW  (NUM_HW),
        .RR_INIT (RR_INIT),
        .TID_W   (TID_W),
        .HW_W    (HW_W)
    ) u_sel (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .flags_i      (flags),
        .grant_hw_i   (grant_hw),
        .grant_idx_i  (HW_W'(req_tid_q)),
        .next_valid_o (nxt_valid),
        .next_tid_o   (nxt_tid)
    );

    // The registered candidate is used only if its flag is still set now.
    always_comb begin
        nxt_live = nxt_valid && flags[nxt_tid];
        nxt_wins = outranks(class_of(32'(nxt_tid), NUM_HW),
                            class_of(32'(cur_tid_q), NUM_HW));
        grant_hw = (state_q == ST_REQ) && sched_ack_i
                   && (32'(req_tid_q) < NUM_HW);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (nxt_live) state_d = ST_REQ;          // launch
            ST_REQ:  if (sched_ack_i) state_d = ST_RUN;       // accept, else hold
            ST_RUN: begin
                if (yield_i)
                    state_d = ST_IDLE;                         // yield
                else if (preempt_i && nxt_live && nxt_wins)
                    state_d = ST_REQ;                          // preempt
            end
            default: state_d = ST_IDLE;
        endcase
        load_req = (state_d == ST_REQ) && (state_q != ST_REQ);
    end

    // State register and held thread ids.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            req_tid_q <= '0;
            cur_tid_q <= '0;
        end else begin
            state_q <= state_d;
            if (load_req)
                req_tid_q <= nxt_tid;
            if ((state_q == ST_REQ) && sched_ack_i)
                cur_tid_q <= req_tid_q;
        end
    end

    // Outputs from the state.
    always_comb begin
        sched_req_o    = (state_q == ST_REQ);
        sched_thread_o = req_tid_q;
        cur_valid_o    = (state_q == ST_RUN);
        cur_thread_o   = cur_tid_q;
        sem_flags_o    = flags;
    end

endmodule

// File: rtl/thread_scheduler_checker.sv
module thread_scheduler_checker #(
    parameter int NUM_HW = 4,
    parameter int NT     = NUM_HW + 2,
    parameter int TID_W  = $clog2(NUM_HW + 2)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             preempt_i,
    input logic             yield_i,
    input logic             int_en_i,
    input logic [NT-1:0]    sem_set_i,
    input logic             clr_valid_i,
    input logic [NT-1:0]    clr_result_o,
    input logic [NT-1:0]    sem_flags_o,
    input logic             sched_req_o,
    input logic [TID_W-1:0] sched_thread_o,
    input logic             sched_ack_i,
    input logic             cur_valid_o,
    input logic [TID_W-1:0] cur_thread_o
);

    assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sched_req_o && !sched_ack_i) |=> (sched_req_o && $stable(sched_thread_o)));

    assert_req_run_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sched_req_o && cur_valid_o));

    assert_hw_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_valid_o && (32'(cur_thread_o) < NUM_HW) && !yield_i)
        |=> (cur_valid_o && $stable(cur_thread_o)));

    assert_coop_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_valid_o && !preempt_i && !yield_i) |=> cur_valid_o);

    assert_clear_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_valid_i && (sem_set_i == '0) && !$rose(int_en_i))
        |=> (sem_flags_o == $past(clr_result_o)));

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sem_set_i != '0) |=> ((sem_flags_o & $past(sem_set_i)) == $past(sem_set_i)));

    assert_int_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(int_en_i) |=> sem_flags_o[NUM_HW]);

    assert_yield_stops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_valid_o && yield_i) |=> !cur_valid_o);

endmodule

bind thread_scheduler thread_scheduler_checker #(
    .NUM_HW (NUM_HW)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .preempt_i      (preempt_i),
    .yield_i        (yield_i),
    .int_en_i       (int_en_i),
    .sem_set_i      (sem_set_i),
    .clr_valid_i    (clr_valid_i),
    .clr_result_o   (clr_result_o),
    .sem_flags_o    (sem_flags_o),
    .sched_req_o    (sched_req_o),
    .sched_thread_o (sched_thread_o),
    .sched_ack_i    (sched_ack_i),
    .cur_valid_o    (cur_valid_o),
    .cur_thread_o   (cur_thread_o)
);

// File: tb/thread_scheduler_tb_top.sv
`timescale 1ns/1ps
module thread_scheduler_tb_top;

    localparam int NUM_HW = 4;
    localparam int NT     = NUM_HW + 2;
    localparam int TID_W  = $clog2(NUM_HW + 2);
    localparam int MK     = NUM_HW;
    localparam int EMU    = NUM_HW + 1;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             preempt_i = 1'b0;
    logic             yield_i = 1'b0;
    logic             int_en_i = 1'b0;
    logic [NT-1:0]    sem_set_i = '0;
    logic             clr_valid_i = 1'b0;
    logic [NT-1:0]    clr_mask_i = '0;
    logic [NT-1:0]    clr_result_o;
    logic [NT-1:0]    sem_flags_o;
    logic             sched_req_o;
    logic [TID_W-1:0] sched_thread_o;
    logic             sched_ack_i = 1'b0;
    logic             cur_valid_o;
    logic [TID_W-1:0] cur_thread_o;

    int checks = 0;
    int errors = 0;
    logic [NT-1:0] model = '0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    thread_scheduler #(.NUM_HW(NUM_HW), .RR_INIT(0)) dut_i (
        .clk_i, .rst_ni, .preempt_i, .yield_i, .int_en_i, .sem_set_i,
        .clr_valid_i, .clr_mask_i, .clr_result_o, .sem_flags_o,
        .sched_req_o, .sched_thread_o, .sched_ack_i, .cur_valid_o, .cur_thread_o
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    task automatic set_bits(input logic [NT-1:0] m);
        sem_set_i = m;
        @(negedge clk_i);
        sem_set_i = '0;
        model |= m;
    endtask

    // Combined clear and set in one cycle; checks the returned value and the landing.
    task automatic clr_set(input logic [NT-1:0] m, input logic [NT-1:0] s, input string req);
        clr_valid_i = 1'b1;
        clr_mask_i  = m;
        sem_set_i   = s;
        #1;
        chk(clr_result_o == (model & ~m), req, int'(clr_result_o), int'(model & ~m));
        @(negedge clk_i);
        clr_valid_i = 1'b0;
        clr_mask_i  = '0;
        sem_set_i   = '0;
        model = (model & ~m) | s;
        chk(sem_flags_o == model, req, int'(sem_flags_o), int'(model));
    endtask

    task automatic wait_req(input int tid, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (sched_req_o) seen = 1'b1;
            else @(negedge clk_i);
        end
        chk(seen && (int'(sched_thread_o) == tid), req, seen ? int'(sched_thread_o) : -1, tid);
    endtask

    task automatic grant(input int tid, input string req);
        wait_req(tid, req);
        sched_ack_i = 1'b1;
        @(negedge clk_i);
        sched_ack_i = 1'b0;
        chk(cur_valid_o && int'(cur_thread_o) == tid, "R5 accept", int'(cur_thread_o), tid);
    endtask

    task automatic do_yield();
        yield_i = 1'b1;
        @(negedge clk_i);
        yield_i = 1'b0;
        chk(!cur_valid_o, "R11 yield", int'(cur_valid_o), 0);
        chk(sem_flags_o == model, "R11 flags kept", int'(sem_flags_o), int'(model));
    endtask

    task automatic hold_check(input int n, input int tid, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            if (sched_req_o || !cur_valid_o || int'(cur_thread_o) != tid) ok = 1'b0;
        end
        chk(ok, req, int'(cur_thread_o), tid);
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1: reset state and idle with no flags
        chk(!sched_req_o, "R1 req", int'(sched_req_o), 0);
        chk(!cur_valid_o, "R1 cur_valid", int'(cur_valid_o), 0);
        chk(sem_flags_o == '0, "R1 flags", int'(sem_flags_o), 0);
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk_i);
                if (sched_req_o) quiet = 1'b0;
            end
            chk(quiet, "R1 no request", int'(sched_req_o), 0);
        end

        // R2/R4: all flags set, round-robin walk with wrap
        set_bits('1);
        grant(0, "R2 hw first");
        for (int t = 1; t < NUM_HW; t++) begin
            do_yield();
            grant(t, "R4 rotate");
        end
        do_yield();
        grant(0, "R4 wrap");
        clr_set(6'h0F, '0, "R8 clear hw");
        do_yield();
        grant(MK, "R3 mk before emu");
        clr_set(6'h10, '0, "R8 clear mk");
        do_yield();
        grant(EMU, "R3 emu last");

        // R6: preemptive mode
        preempt_i = 1'b1;
        set_bits(6'h10);
        wait_req(MK, "R6 mk displaces emu");
        chk(!cur_valid_o, "R6 emu stopped", int'(cur_valid_o), 0);
        grant(MK, "R6 mk runs");
        set_bits(6'h04);
        grant(2, "R6 hw displaces mk");
        set_bits(6'h02);
        hold_check(10, 2, "R6 hw not displaced");

        // R7: cooperative mode
        preempt_i = 1'b0;
        do_yield();
        grant(1, "R4 pointer after 2");
        clr_set(6'h06, '0, "R8 clear hw pair");
        do_yield();
        grant(MK, "R7 mk runs");
        set_bits(6'h01);
        hold_check(10, MK, "R7 no switch without yield");
        do_yield();
        grant(0, "R7 hw after yield");

        // R11 and R5
        clr_set('1, '0, "R8 clear all");
        do_yield();
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk_i);
                if (sched_req_o) quiet = 1'b0;
            end
            chk(quiet, "R11 idle stays idle", int'(sched_req_o), 0);
        end
        set_bits(6'h20);
        wait_req(EMU, "R5 emu offered");
        set_bits(6'h08);
        begin
            bit held = 1'b1;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk_i);
                if (!sched_req_o || int'(sched_thread_o) != EMU) held = 1'b0;
            end
            chk(held, "R5 request held", int'(sched_thread_o), EMU);
        end
        grant(EMU, "R5 late ack");

        // R9: atomic set/clear races
        clr_set(6'h08, 6'h08, "R9 set wins");
        chk(sem_flags_o[3], "R9 bit3 set", int'(sem_flags_o[3]), 1);
        clr_set(6'h20, 6'h01, "R9 other bits");
        chk(sem_flags_o == 6'h09, "R9 result", int'(sem_flags_o), 9);

        // R10: interrupt-enable edge
        int_en_i = 1'b1;
        @(negedge clk_i);
        model |= 6'h10;
        chk(sem_flags_o[MK], "R10 rise wakes mk", int'(sem_flags_o[MK]), 1);
        clr_set(6'h10, '0, "R10 clear mk");
        step(5);
        chk(!sem_flags_o[MK], "R10 level no wake", int'(sem_flags_o[MK]), 0);
        int_en_i = 1'b0;
        step(3);
        chk(!sem_flags_o[MK], "R10 fall no wake", int'(sem_flags_o[MK]), 0);
        int_en_i = 1'b1;
        @(negedge clk_i);
        chk(sem_flags_o[MK], "R10 second rise", int'(sem_flags_o[MK]), 1);
        chk(cur_valid_o && int'(cur_thread_o) == EMU, "R7 emu still running",
            int'(cur_thread_o), EMU);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule